// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two word-wide operands with a single one-bit full adder. It keeps a full parallel interface, so it can stand in for a parallel adder inside a word-wide datapath. A start strobe captures both operands in parallel into shift registers. The adder then handles one bit pair per clock, least significant bit first, and a carry flip-flop carries the carry from one bit to the next. Each sum bit enters a result shift register at its most significant end. After one clock per bit, the full sum is presented as a parallel word and the final carry as a registered flag.

The block trades latency for area. A 32-bit addition takes 32 clocks plus the load clock. The logic that remains is one full-adder cell, three shift registers, a carry flop and a small bit counter. A start strobe that arrives while a sum is in progress is dropped. A start strobe in the cycle that reports completion is accepted, so operations can follow each other with no idle clock between them.

Top module: `serial_word_adder`

## Requirements
- R1: While reset is held and after it is released, `sumOut` is all zeros, `carryOut` is 0 and `done` is 0.
- R2: When `startLoad` is 1 at a rising edge with no operation in progress, both operands are captured at that edge and the carry flip-flop is cleared. A carry left over from an earlier addition never reaches bit 0 of the new sum.
- R3: `done` is 1 for exactly one cycle. That cycle follows the WIDTH-th rising edge after the load edge, and `done` is 0 in every cycle before it.
- R4: While `done` is 1, `sumOut` equals (opA + opB) mod 2^WIDTH for the captured operands.
- R5: While `done` is 1, `carryOut` equals bit WIDTH of the full sum opA + opB. It keeps that value until the next operation completes.
- R6: A `startLoad` pulse while an operation is in progress has no effect. The running sum completes on schedule with the operands captured first.
- R7: While no operation runs and `startLoad` is 0, `sumOut` and `carryOut` do not change.
- R8: A `startLoad` that arrives in the cycle where `done` is 1 starts a new operation, which reports completion WIDTH+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| startLoad | input | 1 | Start strobe; captures both operands when idle |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| sumOut | output | WIDTH | Parallel sum, valid from the `done` cycle onward |
| carryOut | output | 1 | Registered carry out of the top bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
A 4-bit copy is swept over all 256 operand pairs. This covers every carry chain, including a carry that ripples the full width and out of the top. A design that shifted the wrong way, or that fed in the sum from the wrong end, would come out bit-reversed. The full-width copy gets directed patterns and pseudo-random words. A sum that follows one with a carry-out checks that the carry is cleared on load; a design that failed to clear it would come out one too high. Further checks put start pulses in the middle of an operation, where a design that restarted would report the wrong sum or finish late, and run back-to-back starts on the done cycle, where a design that lost that start would never report a second completion.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadEn;   // capture operands, clear carry
    logic shiftEn;  // process one bit pair
    logic lastBit;  // this shift handles the top bit
  } addStrobes_t;

endpackage

// File: rtl/bit_full_add.sv
module bit_full_add (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);

  always_comb begin
    sum  = a ^ b ^ cin;
    cout = (a & b) | (cin & (a ^ b));
  end

endmodule

// File: rtl/serial_add_ctrl.sv
module serial_add_ctrl
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startLoad,
  output addStrobes_t strb,
  output logic        done
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic          busy;
  logic [CW-1:0] bitCount;
  logic          accept;

  always_comb begin
    accept       = startLoad && !busy;
    strb.loadEn  = accept;
    strb.shiftEn = busy;
    strb.lastBit = busy && (bitCount == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitCount <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        bitCount <= '0;
      end else if (busy) begin
        if (bitCount == LAST) begin
          busy     <= 1'b0;
          bitCount <= '0;
          done     <= 1'b1;
        end else begin
          bitCount <= bitCount + 1'b1;
        end
      end
    end
  end

  // R3: completion is a single-cycle pulse
  a_r3_done_single : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: the last shift is followed by done
  a_r3_done_after_last : assert property (@(posedge clk) disable iff (!rstN)
    strb.lastBit |=> done);

  // R6: a running operation advances one bit per clock whatever startLoad does
  a_r6_busy_advance : assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.lastBit) |=> (busy && bitCount == $past(bitCount) + 1'b1));

  // R8: a start on the done cycle is accepted
  a_r8_start_on_done : assert property (@(posedge clk) disable iff (!rstN)
    (done && startLoad) |=> busy);

endmodule

// File: rtl/serial_add_dp.sv
module serial_add_dp
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  addStrobes_t      strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  logic [WIDTH-1:0] shA;
  logic [WIDTH-1:0] shB;
  logic [WIDTH-1:0] resultQ;
  logic             carryQ;
  logic             carryOutQ;
  logic             sumBit;
  logic             carryNext;

  bit_full_add u_fa (
    .a    (shA[0]),
    .b    (shB[0]),
    .cin  (carryQ),
    .sum  (sumBit),
    .cout (carryNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shA       <= '0;
      shB       <= '0;
      resultQ   <= '0;
      carryQ    <= 1'b0;
      carryOutQ <= 1'b0;
    end else if (strb.loadEn) begin
      shA    <= opA;
      shB    <= opB;
      carryQ <= 1'b0;
    end else if (strb.shiftEn) begin
      shA     <= shA >> 1;
      shB     <= shB >> 1;
      resultQ <= {sumBit, resultQ[WIDTH-1:1]};
      carryQ  <= carryNext;
      if (strb.lastBit) carryOutQ <= carryNext;
    end
  end

  assign sumOut   = resultQ;
  assign carryOut = carryOutQ;

  // R2: load clears the running carry
  a_r2_carry_clear : assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> (carryQ == 1'b0));

  // R2: load captures operand A as presented
  a_r2_capture_a : assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> (shA == $past(opA)));

  // R7: result holds when nothing is shifting
  a_r7_sum_hold : assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadEn && !strb.shiftEn) |=> $stable(resultQ));

  // R5: carry-out only changes on the last shift
  a_r5_cout_hold : assert property (@(posedge clk) disable iff (!rstN)
    !strb.lastBit |=> $stable(carryOutQ));

endmodule

// File: rtl/serial_word_adder.sv
module serial_word_adder
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startLoad,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             done
);

  addStrobes_t strb;

  serial_add_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startLoad (startLoad),
    .strb      (strb),
    .done      (done)
  );

  serial_add_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  // R1: outputs are quiet while reset is held
  a_r1_reset_quiet : assert property (@(posedge clk)
    !rstN |=> (sumOut == '0 && !carryOut && !done));

endmodule

// File: tb/test_serial_word_adder.sv
module test_serial_word_adder;

  localparam int W  = 32;
  localparam int WS = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startLoad = 1'b0;
  logic [W-1:0]  opA = '0, opB = '0;
  logic [W-1:0]  sumOut;
  logic          carryOut, done;

  logic          sStart = 1'b0;
  logic [WS-1:0] sA = '0, sB = '0;
  logic [WS-1:0] sSum;
  logic          sCout, sDone;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  serial_word_adder #(.WIDTH(W)) i_serial_word_adder (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .opA(opA), .opB(opB),
    .sumOut(sumOut), .carryOut(carryOut), .done(done));

  serial_word_adder #(.WIDTH(WS)) i_serial_word_adder_small (
    .clk(clk), .rstN(rstN), .startLoad(sStart), .opA(sA), .opB(sB),
    .sumOut(sSum), .carryOut(sCout), .done(sDone));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; strobe start for one cycle.
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    startLoad = 1'b1; opA = a; opB = b;
    @(negedge clk);
    startLoad = 1'b0; opA = ~a; opB = 32'h5A5A_A5A5;
  endtask

  // Called right after issue; returns at the done negedge.
  task automatic finish(input logic [W-1:0] a, input logic [W-1:0] b, input bit intrude);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b};
    for (int k = 1; k < W; k++) begin
      if (intrude && (k == 5 || k == W-1)) begin
        startLoad = 1'b1; opA = 32'hFFFF_FFFF; opB = 32'h1;  // R6 intruding start
      end
      @(negedge clk);
      startLoad = 1'b0;
      if (done) check("R3 early done", 1, 0);
    end
    @(negedge clk);
    check("R3 done", done, 1);
    check("R4 sum", sumOut, full[W-1:0]);
    check("R5 carry", carryOut, full[W]);
    if (intrude) check("R6 ignored start", sumOut, full[W-1:0]);
  endtask

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit intrude);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b};
    issue(a, b);
    finish(a, b, intrude);
    @(negedge clk);
    check("R3 single pulse", done, 0);
    repeat (3) @(negedge clk);
    check("R7 sum hold", sumOut, full[W-1:0]);
    check("R7/R5 carry hold", carryOut, full[W]);
  endtask

  task automatic runSmall(input logic [WS-1:0] a, input logic [WS-1:0] b);
    logic [WS:0] full;
    full = {1'b0, a} + {1'b0, b};
    sStart = 1'b1; sA = a; sB = b;
    @(negedge clk);
    sStart = 1'b0; sA = ~a; sB = ~b;
    repeat (WS-1) @(negedge clk);
    check("R3 small early", sDone, 0);
    @(negedge clk);
    check("R3 small done", sDone, 1);
    check("R4 small sum", sSum, full[WS-1:0]);
    check("R5 small carry", sCout, full[WS]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] ra, rb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sum", sumOut, 0);
    check("R1 carry", carryOut, 0);
    check("R1 done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {sumOut, carryOut, done}, 0);

    // R4/R5 directed patterns
    runOp(32'h0000_0000, 32'h0000_0000, 0);
    runOp(32'hFFFF_FFFF, 32'h0000_0001, 0);   // full ripple, carry out
    runOp(32'h0000_0000, 32'h0000_0001, 0);   // R2: stale carry must be cleared
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    runOp(32'h8000_0000, 32'h8000_0000, 0);
    runOp(32'h1234_5678, 32'h0000_0001, 0);   // LSB-first order
    runOp(32'hAAAA_AAAA, 32'h5555_5555, 0);
    // R6 start pulses during an operation
    runOp(32'hDEAD_BEEF, 32'h0101_0101, 1);
    runOp(32'h7FFF_FFFF, 32'h0000_0001, 1);
    // R8 back-to-back: start on the done cycle
    issue(32'hFFFF_0000, 32'h0001_0000);
    finish(32'hFFFF_0000, 32'h0001_0000, 0);
    issue(32'h0000_0003, 32'h0000_0004);
    finish(32'h0000_0003, 32'h0000_0004, 0);
    check("R8 second op", sumOut, 32'h7);
    check("R2 carry cleared after back-to-back", carryOut, 0);
    @(negedge clk);
    // pseudo-random words
    for (int i = 0; i < 24; i++) begin
      ra = $urandom; rb = $urandom;
      runOp(ra, rb, 0);
    end
    // exhaustive sweep of the narrow copy
    for (int a = 0; a < (1 << WS); a++)
      for (int b = 0; b < (1 << WS); b++)
        runSmall(WS'(a), WS'(b));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule